// File: doc/BRIEF.md
# Configurable GPIO Function Controller

This block manages six general-purpose pads of a radio transceiver's digital core. Each pad has a one-byte control register. Bit 7 of that byte sets the direction and bits 6:0 hold a function code. On an output pad the code picks an internal status signal to drive onto the pad. On an input pad the code picks a command strobe, which fires on a chosen edge of the pad. A per-pad polarity register does two jobs: it inverts the pad output, and it selects the active input edge.

Software accesses the configuration through a simple register write and combinational read port. A pulse on the low-power entry input puts every register back to its reset value, so software must program the pads again after waking. Input pads go through a two-flop synchronizer before edge detection. Each detected edge produces a one-cycle pulse on the strobe output that matches the code.

Top module: `gpio_func_ctrl`

## Requirements
- R1: Addresses 0 to 5 hold the control bytes of pads 0 to 5. They are written on a clock edge with `reg_we_i` high, and they read back on `reg_rdata_o` with reset values 0x00, 0x27, 0x28, 0x29, 0x2A and 0x90.
- R2: Address 6 holds the polarity bits in bits 5:0 and resets to 0x3F. Address 7 holds storage-only pull-up bits in bits 5:0 and an extra-drive bit in bit 7, and resets to 0x00. Bits of these two registers that are not listed read as 0.
- R3: When control bit 7 is 0 the pad is an output and `pad_oe_o` is 1. When bit 7 is 1 the pad is an input: `pad_oe_o` is 0 and `pad_out_o` is 0.
- R4: For an output pad, a code c in the range 1 to STAT_W drives `status_i[c]`. A code above STAT_W (default 48) drives 0.
- R5: Code 0x00 drives an internal reference clock of CLK_HZ/(2*DIV_HALF) with equal halves. With the defaults this is 25 cycles high and 25 cycles low, which is 1 MHz from 50 MHz.
- R6: A polarity bit of 1 passes the selected signal to the pad unchanged. A polarity bit of 0 inverts it.
- R7: For an input pad with code 0x00 to 0x0F and polarity 1, a rising edge on `pad_in_i` pulses `strobe_o[code]` high for one cycle. The pulse starts after the second clock edge that follows the pad change. For example, control byte 0x85 fires strobe 5.
- R8: With polarity 0 only a falling edge fires the strobe, and a rising edge is ignored. With polarity 1 a falling edge is ignored.
- R9: No strobe fires for an input pad with a code of 0x10 or above, or for a pad set as an output.
- R10: A high `lpm_enter_i` at a clock edge reloads all eight registers with their reset values. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpm_enter_i | input | 1 | Deep low-power entry; reloads reset setup |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| status_i | input | STAT_W | Internal status signals, indexed 1 to STAT_W |
| strobe_o | output | 16 | Command strobe pulses, one bit per code |
| pad_oe_o | output | 6 | Pad output enable |
| pad_out_o | output | 6 | Pad output value |
| pad_in_i | input | 6 | Pad input value |

## Verification
A corrupted control byte shows on the ports in the same cycle. It changes `reg_rdata_o`, the pad's output enable, or which status bit reaches the pad. A wrong polarity bit shows at once as an inverted pad level. In input mode it instead shows as a strobe on the wrong edge, two cycles after the pad change. Faults in the synchronizer or the edge history show as a pulse that is late, doubled or missing in the window two cycles after the pad change. A fault in the divider shows within one reference period as a half-period other than 25 cycles.

// File: rtl/gpio_func_pkg.sv
`timescale 1ns/1ps
package gpio_func_pkg;
  localparam int NPIN     = 6;
  localparam int ADDR_W   = 3;
  localparam int CODE_W   = 7;
  localparam int N_STROBE = 16;
  localparam logic [ADDR_W-1:0] ADDR_POL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_AUX = 3'd7;
  localparam logic [NPIN-1:0]   POL_RST  = '1;

  function automatic logic [7:0] ctrl_rst(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h27;
      2:       return 8'h28;
      3:       return 8'h29;
      4:       return 8'h2A;
      default: return 8'h90;
    endcase
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
module gpio_cfg_regs
  import gpio_func_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lpm_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 rdata_o,
  output logic [NPIN-1:0][7:0]       ctrl_o,
  output logic [NPIN-1:0]            pol_o
);
  logic [NPIN-1:0][7:0] ctrl_q;
  logic [NPIN-1:0]      pol_q;
  logic [NPIN-1:0]      pull_q;
  logic                 drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || lpm_i) begin
      for (int i = 0; i < NPIN; i++) ctrl_q[i] <= ctrl_rst(i);
      pol_q   <= POL_RST;
      pull_q  <= '0;
      drive_q <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NPIN; i++)
        if (addr_i == ADDR_W'(i)) ctrl_q[i] <= wdata_i;
      if (addr_i == ADDR_POL) pol_q <= wdata_i[NPIN-1:0];
      if (addr_i == ADDR_AUX) begin
        pull_q  <= wdata_i[NPIN-1:0];
        drive_q <= wdata_i[7];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NPIN; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = ctrl_q[i];
    if (addr_i == ADDR_POL) rdata_o[NPIN-1:0] = pol_q;
    if (addr_i == ADDR_AUX) begin
      rdata_o[NPIN-1:0] = pull_q;
      rdata_o[7]        = drive_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign pol_o  = pol_q;

  // R10
  lpm_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpm_i |=> (pol_q == POL_RST && pull_q == '0 && !drive_q &&
               ctrl_q[0] == 8'h00 && ctrl_q[NPIN-1] == 8'h90));

  // R1
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lpm_i && addr_i == 3'd2) |=> ctrl_q[2] == $past(wdata_i));
endmodule

// File: rtl/gpio_ref_clk.sv
`timescale 1ns/1ps
module gpio_ref_clk #(
  parameter int DIV_HALF = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = clk_q;

  // R5
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_q != $past(clk_q)) |-> ($past(cnt_q) == CNT_MAX));
endmodule

// File: rtl/gpio_pin_slice.sv
`timescale 1ns/1ps
module gpio_pin_slice
  import gpio_func_pkg::*;
#(
  parameter int STAT_W = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      ctrl_i,
  input  logic            pol_i,
  input  logic            refclk_i,
  input  logic [STAT_W:1] status_i,
  input  logic            pad_in_i,
  output logic            pad_oe_o,
  output logic            pad_out_o,
  output logic            fire_o,
  output logic [3:0]      fire_code_o
);
  logic [CODE_W-1:0] code;
  logic              is_in;
  logic              sel;
  logic              sync1_q, sync2_q, prev_q;
  logic              edge_hit;

  assign code  = ctrl_i[CODE_W-1:0];
  assign is_in = ctrl_i[7];

  always_comb begin
    sel = 1'b0;
    if (code == '0) sel = refclk_i;
    for (int j = 1; j <= STAT_W; j++)
      if (code == CODE_W'(j)) sel = status_i[j];
  end

  assign pad_oe_o  = ~is_in;
  assign pad_out_o = ~is_in & (sel ^ ~pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pad_in_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // polarity 1: rising edge, 0: falling edge
  assign edge_hit    = pol_i ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
  assign fire_o      = is_in & (code < CODE_W'(N_STROBE)) & edge_hit;
  assign fire_code_o = code[3:0];

  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (!fire_o || pol_i != $past(pol_i)));
endmodule

// File: rtl/gpio_func_ctrl.sv
`timescale 1ns/1ps
module gpio_func_ctrl
  import gpio_func_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int REF_HZ = 1_000_000,
  parameter int STAT_W = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lpm_enter_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic [STAT_W:1]     status_i,
  output logic [N_STROBE-1:0] strobe_o,
  output logic [NPIN-1:0]     pad_oe_o,
  output logic [NPIN-1:0]     pad_out_o,
  input  logic [NPIN-1:0]     pad_in_i
);
  localparam int DIV_HALF = CLK_HZ / (2 * REF_HZ);

  logic [NPIN-1:0][7:0] ctrl;
  logic [NPIN-1:0]      pol;
  logic                 refclk;
  logic [NPIN-1:0]      fire;
  logic [NPIN-1:0][3:0] fire_code;

  gpio_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lpm_i   (lpm_enter_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .pol_o   (pol)
  );

  gpio_ref_clk #(.DIV_HALF(DIV_HALF)) u_refclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clk_o  (refclk)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    gpio_pin_slice #(.STAT_W(STAT_W)) u_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_i      (ctrl[p]),
      .pol_i       (pol[p]),
      .refclk_i    (refclk),
      .status_i    (status_i),
      .pad_in_i    (pad_in_i[p]),
      .pad_oe_o    (pad_oe_o[p]),
      .pad_out_o   (pad_out_o[p]),
      .fire_o      (fire[p]),
      .fire_code_o (fire_code[p])
    );
  end

  always_comb begin
    strobe_o = '0;
    for (int p = 0; p < NPIN; p++)
      if (fire[p]) strobe_o[fire_code[p]] = 1'b1;
  end

  // R9
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strobe_o) |-> (pad_oe_o != '1));
endmodule

// File: tb/gpio_func_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_func_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lpm = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [48:1] status = '0;
  logic [15:0] strobe;
  logic [5:0]  oe, pout;
  logic [5:0]  pin = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_func_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lpm_enter_i(lpm), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .status_i(status), .strobe_o(strobe), .pad_oe_o(oe),
    .pad_out_o(pout), .pad_in_i(pin)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk); addr = a; #1;
    check(req, int'(rdata), int'(e));
  endtask

  // drive pad, expect strobe value exp only in the second sample, zero elsewhere
  task automatic watch(input string req, input int p, input logic lvl, input logic [15:0] exp);
    int extra = 0;
    @(negedge clk); pin[p] = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 2) check(req, int'(strobe), int'(exp));
      else if (strobe != '0) extra++;
    end
    check({req, " quiet"}, extra, 0);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl0", 3'd0, 8'h00);
    rd_chk("R1 ctrl1", 3'd1, 8'h27);
    rd_chk("R1 ctrl2", 3'd2, 8'h28);
    rd_chk("R1 ctrl3", 3'd3, 8'h29);
    rd_chk("R1 ctrl4", 3'd4, 8'h2A);
    rd_chk("R1 ctrl5", 3'd5, 8'h90);
    rd_chk("R2 pol", 3'd6, 8'h3F);
    rd_chk("R2 aux", 3'd7, 8'h00);
    check("R3 reset oe", int'(oe), 6'b011111);
    check("R9 reset strobe", int'(strobe), 0);
  endtask

  task automatic t_regs;
    wr(3'd7, 8'hFF); rd_chk("R2 aux bits", 3'd7, 8'hBF);
    wr(3'd6, 8'hFF); rd_chk("R2 pol bits", 3'd6, 8'h3F);
    wr(3'd3, 8'h5A); rd_chk("R1 write ctrl3", 3'd3, 8'h5A);
    wr(3'd3, 8'h29);
  endtask

  task automatic t_status;
    @(negedge clk); status = '0; status[8'h28] = 1'b1; #1;
    check("R4 sel fifop", int'(pout[4:1]), 4'b0010);
    @(negedge clk); status = '0; status[8'h27] = 1'b1; status[8'h2A] = 1'b1; #1;
    check("R4 sel fifo sfd", int'(pout[4:1]), 4'b1001);
    wr(3'd1, 8'h60);
    @(negedge clk); status = '1; #1;
    check("R4 code above range", int'(pout[1]), 0);
    wr(3'd1, 8'h30); #1;
    check("R4 top code", int'(pout[1]), 1);
    wr(3'd1, 8'h27);
    @(negedge clk); status = '0;
  endtask

  task automatic t_polarity;
    wr(3'd6, 8'h3B); #1;
    check("R6 inverted", int'(pout[2]), 1);
    @(negedge clk); status[8'h28] = 1'b1; #1;
    check("R6 inverted high", int'(pout[2]), 0);
    wr(3'd6, 8'h3F); #1;
    check("R6 positive", int'(pout[2]), 1);
    @(negedge clk); status = '0;
  endtask

  task automatic t_dir;
    @(negedge clk); status = '1;
    wr(3'd3, 8'hA9); #1;
    check("R3 input oe", int'(oe[3]), 0);
    check("R3 input out", int'(pout[3]), 0);
    wr(3'd3, 8'h29); #1;
    check("R3 output oe", int'(oe[3]), 1);
    @(negedge clk); status = '0;
  endtask

  task automatic t_clock;
    logic prv;
    int hi = 0, lo = 0, guard = 0;
    @(negedge clk); prv = pout[0];
    forever begin
      @(negedge clk); guard++;
      if ((!prv && pout[0]) || guard > 200) break;
      prv = pout[0];
    end
    while (pout[0] && hi < 200) begin hi++; @(negedge clk); end
    while (!pout[0] && lo < 200) begin lo++; @(negedge clk); end
    check("R5 high cycles", hi, 25);
    check("R5 low cycles", lo, 25);
  endtask

  task automatic t_strobe;
    wr(3'd2, 8'h85);
    repeat (4) @(negedge clk);
    watch("R7 rising fires 5", 2, 1'b1, 16'h0020);
    watch("R8 falling ignored pol1", 2, 1'b0, 16'h0000);
    wr(3'd6, 8'h3B);
    watch("R8 rising ignored pol0", 2, 1'b1, 16'h0000);
    watch("R8 falling fires", 2, 1'b0, 16'h0020);
    wr(3'd6, 8'h3F);
    wr(3'd4, 8'h8C);
    watch("R7 code 12", 4, 1'b1, 16'h1000);
    pin[4] = 1'b0;
    wr(3'd4, 8'h2A);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_nofunc;
    watch("R9 code 0x10 input", 5, 1'b1, 16'h0000);
    wr(3'd2, 8'h05);
    watch("R9 output pad", 2, 1'b1, 16'h0000);
    pin = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lpm;
    wr(3'd4, 8'h81); wr(3'd6, 8'h00); wr(3'd7, 8'h81);
    @(negedge clk); lpm = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'hFF;
    @(negedge clk); lpm = 1'b0; we = 1'b0;
    rd_chk("R10 ctrl0", 3'd0, 8'h00);
    rd_chk("R10 ctrl2", 3'd2, 8'h28);
    rd_chk("R10 ctrl4", 3'd4, 8'h2A);
    rd_chk("R10 pol", 3'd6, 8'h3F);
    rd_chk("R10 aux", 3'd7, 8'h00);
    check("R10 oe", int'(oe), 6'b011111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_status();
    t_polarity();
    t_dir();
    t_clock();
    t_strobe();
    t_nofunc();
    t_lpm();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule